// File: doc/BRIEF.md
# Serial Byte-Store Slave with Timed Write

This block models a small nonvolatile byte store behind a four-wire serial port: an active-low select, a serial clock, a data input and a data output. It holds 128 bytes in flip-flops. The block samples the serial pins with a free-running system clock through a short synchronizer. All of its state lives in that single clock domain. The serial clock therefore has to run well below the system clock: each half period must last several system cycles.

A frame has three fields, each sent least-significant bit first. The first is an address field of eight bits, made of seven address bits and a trailing bit that must be 0. The second is a command field of eight bits, made of a four-bit code and four 0 bits. The third is an optional data byte. The block can read a byte, program a byte, erase every byte, report its ready level, and switch write protection on or off. Program and erase are started by the frame and then finish on an internal cycle counter. They keep running after the select line is released. While such an operation is running, only the status command is obeyed.

Top module: `sprom_serial_mem`

## Requirements
- R1: A frame is eight address bits (A0..A6, then a bit that must be 0), then the code bits C0..C3, then four bits that must be 0, then data D0..D7. Each field is sent in that order. A frame whose eighth address bit is 1, or whose four trailing command bits are not all 0, is discarded with no effect.
- R2: The code sequences C0,C1,C2,C3 are: read 1,0,0,0; program 0,1,1,0; erase all 0,0,1,1; status 1,0,1,1; unlock 1,0,0,1; lock 1,1,0,1. Any other code is discarded with no effect.
- R3: A frame is accepted only if the serial clock is high when the select line falls. A frame begun with the clock low is ignored in full until the select line next goes high.
- R4: Read shifts out the addressed byte D0 first, with one bit changing on each falling serial-clock edge after the command field.
- R5: Program stores the data byte at the address once PROG_CYCLES system cycles have passed. The operation completes even if the select line is raised first.
- R6: Erase all sets every location to 0x00 once PROG_CYCLES system cycles have passed.
- R7: Status drives the output with the ready level until the select line rises. The level is 0 while a program or erase runs and 1 otherwise. A run keeps the block not ready for exactly PROG_CYCLES cycles.
- R8: While a program or erase runs, read, program, erase, lock and unlock frames have no effect.
- R9: Program and erase start only while the block is unlocked. Lock keeps the block protected until an unlock is received.
- R10: A program frame cut short before its last data bit changes nothing.
- R11: After reset the block is ready and locked, every location reads 0x00, and the output is low except while a read or status result is being driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| sclk | input | 1 | Serial clock, sampled by clk |
| sdi | input | 1 | Serial data in, taken on rising sclk |
| sdo | output | 1 | Serial data out, read bits or ready level |

## Verification
A table of address and data pairs is programmed and read back. The values are chosen so that their bit patterns differ in both the low and high bits, which catches reversed shift order, wrong bit alignment and address aliasing. Each write is followed by a status frame, which tells a write that really started apart from one that was silently dropped. Directed frames then vary one thing at a time: a set trailing address bit, nonzero command padding, a truncated data field, a select that falls while the clock is low, a frame sent during a running write, and frames sent while locked. Each of these has a distinct state it could corrupt, and the bench reads that state back through a later read or status frame.

// File: rtl/sprom_pkg.sv
package sprom_pkg;
  // code nibble stored with C0 in bit 0
  typedef enum logic [3:0] {
    CMD_READ   = 4'b0001,
    CMD_PROG   = 4'b0110,
    CMD_ERASE  = 4'b1100,
    CMD_STATUS = 4'b1101,
    CMD_UNLOCK = 4'b1001,
    CMD_LOCK   = 4'b1011
  } cmd_e;

  typedef enum logic [1:0] {
    OUT_IDLE = 2'd0,
    OUT_READ = 2'd1,
    OUT_STAT = 2'd2
  } out_e;
endpackage

// File: rtl/sprom_pin_sync.sv
module sprom_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic cs_s,
  output logic sclk_s,
  output logic sdi_s,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_fall
);
  localparam logic [2:0] IDLE_PINS = 3'b110;

  logic [STAGES-1:0][2:0] pipe_q, pipe_n;
  logic                   sclk_d_q, cs_d_q;

  always_comb begin
    pipe_n[0] = {cs_n, sclk, sdi};
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_comb pipe_n[g] = pipe_q[g-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q   <= {STAGES{IDLE_PINS}};
      sclk_d_q <= 1'b1;
      cs_d_q   <= 1'b1;
    end else begin
      pipe_q   <= pipe_n;
      sclk_d_q <= sclk_s;
      cs_d_q   <= cs_s;
    end
  end

  assign cs_s      = pipe_q[STAGES-1][2];
  assign sclk_s    = pipe_q[STAGES-1][1];
  assign sdi_s     = pipe_q[STAGES-1][0];
  assign sclk_rise = sclk_s & ~sclk_d_q;
  assign sclk_fall = ~sclk_s & sclk_d_q;
  assign cs_fall   = ~cs_s & cs_d_q;
endmodule

// File: rtl/sprom_frame.sv
module sprom_frame
  import sprom_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              cs_fall,
  input  logic              sclk_s,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sdi_s,
  input  logic              ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              req_prog,
  output logic              req_erase,
  output logic              req_unlock,
  output logic              req_lock,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdo
);
  localparam int AF       = ADDR_W + 1;
  localparam int CF       = 8;
  localparam int LAST_CMD = AF + CF - 1;
  localparam int LAST_DAT = AF + CF + DATA_W - 1;
  localparam int CW       = $clog2(LAST_DAT + 2);

  logic              act_q, act_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [AF-1:0]     a_q, a_n;
  logic [CF-1:0]     c_q, c_n;
  logic [DATA_W-1:0] d_q, d_n;
  logic              pend_q, pend_n;
  out_e              mode_q, mode_n;
  logic [DATA_W-1:0] osh_q, osh_n;
  logic              sdo_q, sdo_n;
  logic              prog_q, prog_n, erase_q, erase_n;
  logic              unl_q, unl_n, lock_q, lock_n;
  logic [ADDR_W-1:0] wa_q, wa_n;
  logic [DATA_W-1:0] wd_q, wd_n;
  logic [CF-1:0]     cmd_full;
  int                idx;

  assign cmd_full = {sdi_s, c_q[CF-2:0]};
  assign idx      = int'(cnt_q);

  always_comb begin
    act_n = act_q;  cnt_n = cnt_q;  a_n = a_q;  c_n = c_q;  d_n = d_q;
    pend_n = pend_q;  mode_n = mode_q;  osh_n = osh_q;  sdo_n = sdo_q;
    wa_n = wa_q;  wd_n = wd_q;
    prog_n = 1'b0;  erase_n = 1'b0;  unl_n = 1'b0;  lock_n = 1'b0;
    if (cs_s) begin
      act_n  = 1'b0;
      cnt_n  = '0;
      pend_n = 1'b0;
      mode_n = OUT_IDLE;
      sdo_n  = 1'b0;
    end else if (cs_fall) begin
      act_n = sclk_s;
      cnt_n = '0;
    end else begin
      if (act_q && sclk_rise) begin
        if (idx < AF)             a_n[idx] = sdi_s;
        else if (idx < AF + CF)   c_n[idx-AF] = sdi_s;
        else if (idx <= LAST_DAT) d_n[idx-AF-CF] = sdi_s;
        if (idx <= LAST_DAT) cnt_n = cnt_q + 1'b1;
        if (idx == LAST_CMD) begin
          if (a_q[AF-1] || (cmd_full[CF-1:4] != '0)) begin
            act_n = 1'b0;
          end else begin
            case (cmd_full[3:0])
              CMD_STATUS: mode_n = OUT_STAT;
              CMD_READ: if (ready) begin
                mode_n = OUT_READ;
                osh_n  = rd_data;
              end
              CMD_PROG:   pend_n  = ready;
              CMD_ERASE:  erase_n = ready;
              CMD_UNLOCK: unl_n   = ready;
              CMD_LOCK:   lock_n  = ready;
              default:    act_n   = 1'b0;
            endcase
          end
        end
        if (idx == LAST_DAT && pend_q) begin
          prog_n = ready;
          wa_n   = a_q[ADDR_W-1:0];
          wd_n   = {sdi_s, d_q[DATA_W-2:0]};
          pend_n = 1'b0;
        end
      end
      if (sclk_fall && mode_q == OUT_READ) begin
        sdo_n = osh_q[0];
        osh_n = osh_q >> 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;  cnt_q <= '0;  a_q <= '0;  c_q <= '0;  d_q <= '0;
      pend_q <= 1'b0;  mode_q <= OUT_IDLE;  osh_q <= '0;  sdo_q <= 1'b0;
      prog_q <= 1'b0;  erase_q <= 1'b0;  unl_q <= 1'b0;  lock_q <= 1'b0;
      wa_q <= '0;  wd_q <= '0;
    end else begin
      act_q <= act_n;  cnt_q <= cnt_n;  a_q <= a_n;  c_q <= c_n;  d_q <= d_n;
      pend_q <= pend_n;  mode_q <= mode_n;  osh_q <= osh_n;  sdo_q <= sdo_n;
      prog_q <= prog_n;  erase_q <= erase_n;  unl_q <= unl_n;  lock_q <= lock_n;
      wa_q <= wa_n;  wd_q <= wd_n;
    end
  end

  assign rd_addr    = a_q[ADDR_W-1:0];
  assign req_prog   = prog_q;
  assign req_erase  = erase_q;
  assign req_unlock = unl_q;
  assign req_lock   = lock_q;
  assign wr_addr    = wa_q;
  assign wr_data    = wd_q;
  assign sdo        = (mode_q == OUT_STAT) ? ready :
                      (mode_q == OUT_READ) ? sdo_q : 1'b0;
endmodule

// File: rtl/sprom_store.sv
module sprom_store #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_prog,
  input  logic              req_erase,
  input  logic              req_unlock,
  input  logic              req_lock,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              ready,
  output logic              wp
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int TW    = $clog2(PROG_CYCLES + 1);
  localparam logic [TW-1:0] T_LOAD = TW'(PROG_CYCLES - 1);

  logic                   ready_q, ready_n, wp_q, wp_n;
  logic [TW-1:0]          tmr_q, tmr_n;
  logic                   op_erase_q, op_erase_n;
  logic [ADDR_W-1:0]      op_addr_q, op_addr_n;
  logic [DATA_W-1:0]      op_data_q, op_data_n;
  logic                   start, commit;
  logic [DEPTH-1:0][DATA_W-1:0] mem_q;

  assign start  = ready_q && !wp_q && (req_prog || req_erase);
  assign commit = !ready_q && (tmr_q == '0);

  always_comb begin
    ready_n = ready_q;  wp_n = wp_q;  tmr_n = tmr_q;
    op_erase_n = op_erase_q;  op_addr_n = op_addr_q;  op_data_n = op_data_q;
    if (start) begin
      ready_n    = 1'b0;
      tmr_n      = T_LOAD;
      op_erase_n = req_erase;
      op_addr_n  = wr_addr;
      op_data_n  = wr_data;
    end else if (commit) begin
      ready_n = 1'b1;
    end else if (!ready_q) begin
      tmr_n = tmr_q - 1'b1;
    end
    if (ready_q && req_unlock) wp_n = 1'b0;
    if (ready_q && req_lock)   wp_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b1;  wp_q <= 1'b1;  tmr_q <= '0;
      op_erase_q <= 1'b0;  op_addr_q <= '0;  op_data_q <= '0;
    end else begin
      ready_q <= ready_n;  wp_q <= wp_n;  tmr_q <= tmr_n;
      op_erase_q <= op_erase_n;  op_addr_q <= op_addr_n;  op_data_q <= op_data_n;
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      logic we;
      assign we = commit && (op_erase_q || (op_addr_q == ADDR_W'(i)));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  mem_q[i] <= '0;
        else if (we) mem_q[i] <= op_erase_q ? '0 : op_data_q;
      end
    end
  endgenerate

  assign rd_data = mem_q[rd_addr];
  assign ready   = ready_q;
  assign wp      = wp_q;
endmodule

// File: rtl/sprom_serial_mem.sv
module sprom_serial_mem #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic sdo
);
  logic              cs_s, sclk_s, sdi_s, sclk_rise, sclk_fall, cs_fall;
  logic              ready, wp;
  logic              req_prog, req_erase, req_unlock, req_lock;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;

  sprom_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .cs_s(cs_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_fall(cs_fall)
  );

  sprom_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_fall(cs_fall),
    .sclk_s(sclk_s), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .sdi_s(sdi_s), .ready(ready), .rd_data(rd_data), .rd_addr(rd_addr),
    .req_prog(req_prog), .req_erase(req_erase),
    .req_unlock(req_unlock), .req_lock(req_lock),
    .wr_addr(wr_addr), .wr_data(wr_data), .sdo(sdo)
  );

  sprom_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .req_prog(req_prog), .req_erase(req_erase),
    .req_unlock(req_unlock), .req_lock(req_lock),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .ready(ready), .wp(wp)
  );
endmodule

// File: rtl/sprom_chk.sv
module sprom_chk #(
  parameter int PROG_CYCLES = 200
) (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic ready,
  input logic wp,
  input logic sdo
);
  localparam int BW = $clog2(PROG_CYCLES + 2);
  logic [BW-1:0] busy_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_len_q <= '0;
    else if (!ready) busy_len_q <= busy_len_q + 1'b1;
    else             busy_len_q <= '0;
  end

  AST_SDO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && $past(cs_s)) |-> !sdo); // R11
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (busy_len_q == BW'(PROG_CYCLES))); // R7
  AST_START_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> !wp); // R9
  AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(wp)); // R8
endmodule

bind sprom_serial_mem sprom_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .ready(ready), .wp(wp), .sdo(sdo)
);

// File: tb/sprom_serial_mem_tb.sv
module sprom_serial_mem_tb;
  localparam int PROG = 600;
  localparam int HALF = 6;
  localparam logic [3:0] C_RD = 4'b0001, C_PRG = 4'b0110, C_ERA = 4'b1100,
                         C_BSY = 4'b1101, C_UNL = 4'b1001, C_LCK = 4'b1011;
  localparam logic [15:0] VEC [6] = '{16'h05_A5, 16'h00_3C, 16'h7F_FF,
                                      16'h11_01, 16'h40_80, 16'h2A_5A};

  logic clk, rst_n, cs_n, sclk, sdi, sdo;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] got;

  sprom_serial_mem #(.PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo));

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] af, input logic [3:0] c, input logic [3:0] tail,
                      input int nbits, input logic [7:0] d, input bit low_start,
                      output logic [7:0] rd);
    rd = '0;
    cs_n = 1; sclk = 1; repeat (2*HALF) @(negedge clk);
    if (low_start) begin sclk = 0; repeat (HALF) @(negedge clk); end
    cs_n = 0; repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      logic b;
      b = (i < 8) ? af[i] : (i < 12) ? c[i-8] : (i < 16) ? tail[i-12] : d[i-16];
      sclk = 0; sdi = b;
      repeat (HALF) @(negedge clk);
      if (i >= 16) rd[i-16] = sdo;
      sclk = 1;
      repeat (HALF) @(negedge clk);
    end
    cs_n = 1; sclk = 1; repeat (2*HALF) @(negedge clk);
  endtask

  task automatic rd_byte(input logic [6:0] a, output logic [7:0] v);
    xfer({1'b0, a}, C_RD, 4'h0, 24, 8'h00, 0, v);
  endtask
  task automatic prog(input logic [6:0] a, input logic [7:0] v);
    logic [7:0] x;
    xfer({1'b0, a}, C_PRG, 4'h0, 24, v, 0, x);
  endtask
  task automatic cmd(input logic [3:0] c);
    logic [7:0] x;
    xfer(8'h00, c, 4'h0, 16, 8'h00, 0, x);
  endtask
  task automatic status(output logic [7:0] v);
    xfer(8'h00, C_BSY, 4'h0, 24, 8'h00, 0, v);
  endtask
  task automatic settle;
    repeat (PROG + 100) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R5 watchdog actual=timeout expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 0; cs_n = 1; sclk = 1; sdi = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R11 idle sdo", {7'b0, sdo}, 8'h00);
    rd_byte(7'h00, v); chk("R11 reset contents", v, 8'h00);

    // R9: locked at reset, program must not start
    prog(7'h05, 8'hA5);
    status(v); chk("R9 locked program did not start", v, 8'hFF);
    rd_byte(7'h05, v); chk("R9 locked program no write", v, 8'h00);

    cmd(C_UNL);
    for (int k = 0; k < 6; k++) begin
      prog(VEC[k][14:8], VEC[k][7:0]);
      status(v); chk("R7 status busy during program", v, 8'h00);
      settle;
      status(v); chk("R7 status ready after program", v, 8'hFF);
      rd_byte(VEC[k][14:8], v); chk("R4 R5 readback", v, VEC[k][7:0]);
    end

    // R8: read and program ignored while busy
    prog(7'h00, 8'hC3);
    rd_byte(7'h05, v); chk("R8 read ignored while busy", v, 8'h00);
    prog(7'h05, 8'h99);
    settle;
    rd_byte(7'h00, v); chk("R5 completes after cs release", v, 8'hC3);
    rd_byte(7'h05, v); chk("R8 program ignored while busy", v, 8'hA5);

    // R10: truncated program
    xfer(8'h11, C_PRG, 4'h0, 20, 8'hEE, 0, v);
    status(v); chk("R10 truncated frame no start", v, 8'hFF);
    rd_byte(7'h11, v); chk("R10 truncated frame no write", v, 8'h01);

    // R3: select falls with clock low
    xfer(8'h11, C_PRG, 4'h0, 24, 8'h77, 1, v);
    settle;
    rd_byte(7'h11, v); chk("R3 frame with clock low ignored", v, 8'h01);

    // R1: trailing address bit set, nonzero command padding
    xfer(8'h91, C_PRG, 4'h0, 24, 8'h66, 0, v);
    settle;
    rd_byte(7'h11, v); chk("R1 address bit7 set discarded", v, 8'h01);
    xfer(8'h11, C_PRG, 4'h2, 24, 8'h55, 0, v);
    settle;
    rd_byte(7'h11, v); chk("R1 command padding nonzero discarded", v, 8'h01);

    // R2: unknown code then lock, unknown must not unlock
    cmd(C_LCK);
    cmd(4'b1111);
    prog(7'h2A, 8'h00);
    status(v); chk("R2 unknown code no unlock", v, 8'hFF);
    cmd(C_ERA);
    status(v); chk("R9 erase blocked while locked", v, 8'hFF);
    rd_byte(7'h2A, v); chk("R9 lock persists", v, 8'h5A);

    // R6: erase all
    cmd(C_UNL);
    cmd(C_ERA);
    status(v); chk("R6 erase busy", v, 8'h00);
    settle;
    rd_byte(7'h7F, v); chk("R6 erased 7F", v, 8'h00);
    rd_byte(7'h2A, v); chk("R6 erased 2A", v, 8'h00);
    rd_byte(7'h00, v); chk("R6 erased 00", v, 8'h00);
    chk("R11 idle sdo after frames", {7'b0, sdo}, 8'h00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule